// File: doc/BRIEF.md
# Multiplexed-Bus Parallel Port Interface

This block connects a controller bus, on which the low address byte and the data byte share one set of lines, to a bank of three 8-bit general-purpose ports and an external RAM. While the address-latch strobe is high the block captures the low byte from the shared lines. It joins that byte with the separate high address byte to form a 16-bit address. From this address it drives a select for the RAM or for its own four-register port unit, and never both at once.

Each of the three ports works in plain input/output mode. A control word sets the direction of port A, port B and the two halves of port C. Port C bits can also be set or cleared one at a time. Pins are not modelled as tri-state. Each port has an output value bus and a per-bit output enable, so the high-impedance state can be seen directly as enable bits at zero.

Top module: `mux_bus_pio`

## Requirements
- R1: The low address byte is taken from `ad_in` on every clock edge at which `ale` is high, and is held while `ale` is low. Every decode uses this held copy. A change on `ad_in` after `ale` falls does not change `io_cs` or `ram_cs`.
- R2: The port unit is selected (`io_cs`=1) only for the full addresses 0x8000 (port A), 0x8001 (port B), 0x8002 (port C) and 0x8003 (control). It is not selected for any other address, such as 0x8004 or 0xFFFF.
- R3: `ram_cs` is 1 exactly for addresses below 0x8000. `ram_cs` and `io_cs` are never both 1.
- R4: Reset is active high. While `rst` is high and after it is released, every output enable is 0, every output latch is 0, and the control register reads 0x9B.
- R5: A control write with bit 7 = 1 is a direction word. Bit 4 sets port A, bit 3 sets upper port C (bits 7:4), bit 1 sets port B, and bit 0 sets lower port C (bits 3:0). A value of 1 means input (enables 0) and 0 means output (enables 1). For example, 0x9A makes only lower port C an output.
- R6: A control write with bit 7 = 0 changes one port C latch bit. Bits 3:1 select the bit number and bit 0 is the new value. Port directions and the other latch bits stay unchanged.
- R7: A direction word write clears the port A, B and C output latches to 0.
- R8: A port read returns the output latch for bits configured as output and the pin value sampled one clock earlier for bits configured as input. Port C is resolved separately for each nibble.
- R9: A register write takes effect at the clock edge where `wr` is seen low after being high, provided the port unit is selected. It uses the `ad_in` value captured while `wr` was high. A write to any address outside the unit changes no port state.
- R10: `ad_oe` is 1 only while `rd` is high and the port unit is selected. `ad_out` then carries the read value.
- R11: A read of the control register returns 1 in bit 7, the four direction bits at their R5 positions, and 0 in bits 6, 5 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset |
| ale | input | 1 | Address latch strobe |
| ad_in | input | 8 | Shared low-address/data lines, inbound |
| addr_hi | input | 8 | High address byte |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| ad_out | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ram_cs | output | 1 | External RAM select |
| io_cs | output | 1 | Port unit select |
| pa_in | input | 8 | Port A pins, inbound |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pins, inbound |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pins, inbound |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The bench changes the shared lines to an unrelated value right after the latch strobe falls. A design that decodes from the live bus would drop `io_cs` at that point. It applies 0x9A and mixed words such as 0x92, then reads port C with pins that differ from the latch. This shows whether each nibble follows its own direction. A design that mixed up the bit 0 and bit 3 roles, or read the whole port from one source, would return the wrong nibble. Bit set/reset writes are checked to leave the enables alone, and a direction word is checked to zero the latches. A write aimed at RAM space must leave every port untouched. A design that wrongly accepts it would show a changed control read-back.

// File: rtl/mux_bus_pio.sv
module mux_bus_pio (
  input  logic       clk,
  input  logic       rst,
  input  logic       ale,
  input  logic [7:0] ad_in,
  input  logic [7:0] addr_hi,
  input  logic       rd,
  input  logic       wr,
  output logic [7:0] ad_out,
  output logic       ad_oe,
  output logic       ram_cs,
  output logic       io_cs,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);

  logic [7:0] lo_q, wdat_q;
  logic       wr_q;
  logic       a_in, b_in, cu_in, cl_in;
  logic [7:0] a_lat, b_lat, c_lat;
  logic [7:0] a_smp, b_smp, c_smp;

  always_ff @(posedge clk) begin
    if (rst) lo_q <= 8'h00;
    else if (ale) lo_q <= ad_in;
  end

  wire io_sel = (addr_hi == 8'h80) && (lo_q[7:2] == 6'd0);
  assign io_cs  = io_sel;
  assign ram_cs = ~addr_hi[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      wdat_q <= 8'h00;
    end else begin
      wr_q <= wr;
      if (wr) wdat_q <= ad_in;
    end
  end

  wire wr_fall = wr_q & ~wr;
  wire commit  = wr_fall & io_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_smp <= 8'h00;
      b_smp <= 8'h00;
      c_smp <= 8'h00;
    end else begin
      a_smp <= pa_in;
      b_smp <= pb_in;
      c_smp <= pc_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_in  <= 1'b1;
      b_in  <= 1'b1;
      cu_in <= 1'b1;
      cl_in <= 1'b1;
      a_lat <= 8'h00;
      b_lat <= 8'h00;
      c_lat <= 8'h00;
    end else if (commit) begin
      case (lo_q[1:0])
        2'd0: a_lat <= wdat_q;
        2'd1: b_lat <= wdat_q;
        2'd2: c_lat <= wdat_q;
        default: begin
          if (wdat_q[7]) begin
            a_in  <= wdat_q[4];
            cu_in <= wdat_q[3];
            b_in  <= wdat_q[1];
            cl_in <= wdat_q[0];
            a_lat <= 8'h00;
            b_lat <= 8'h00;
            c_lat <= 8'h00;
          end else begin
            c_lat[wdat_q[3:1]] <= wdat_q[0];
          end
        end
      endcase
    end
  end

  assign pa_out = a_lat;
  assign pb_out = b_lat;
  assign pc_out = c_lat;
  assign pa_oe  = {8{~a_in}};
  assign pb_oe  = {8{~b_in}};
  assign pc_oe  = {{4{~cu_in}}, {4{~cl_in}}};

  wire [7:0] ctrl_rd = {1'b1, 2'b00, a_in, cu_in, 1'b0, b_in, cl_in};

  always_comb begin
    case (lo_q[1:0])
      2'd0:    ad_out = a_in ? a_smp : a_lat;
      2'd1:    ad_out = b_in ? b_smp : b_lat;
      2'd2:    ad_out = {cu_in ? c_smp[7:4] : c_lat[7:4], cl_in ? c_smp[3:0] : c_lat[3:0]};
      default: ad_out = ctrl_rd;
    endcase
  end

  assign ad_oe = rd & io_sel;

  p_sel_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(ram_cs && io_cs));

  p_reset_hiz_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 && pc_out == 8'h00));

  p_mode_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (commit && lo_q[1:0] == 2'd3 && wdat_q[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  p_bsr_keeps_dir_r6: assert property (@(posedge clk) disable iff (rst)
    (commit && lo_q[1:0] == 2'd3 && !wdat_q[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  p_idle_no_change_r9: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pc_oe) && $stable(pa_oe)));

  p_read_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !rd |-> !ad_oe);

endmodule

// File: tb/sim_mux_bus_pio.sv
module sim_mux_bus_pio;
  logic clk = 0, rst = 1, ale = 0, rd = 0, wr = 0;
  logic [7:0] ad_in = 0, addr_hi = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] ad_out, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic ad_oe, ram_cs, io_cs;
  int vecs = 0, bad = 0;
  bit smp = 0, done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  mux_bus_pio u0 (.clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .addr_hi(addr_hi),
    .rd(rd), .wr(wr), .ad_out(ad_out), .ad_oe(ad_oe), .ram_cs(ram_cs), .io_cs(io_cs),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out),
    .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

  always @(negedge clk) if (smp) begin
    logic [7:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    vecs++;
    if (!ad_oe || ad_out !== e) begin
      bad++;
      $display("FAIL %s: read got %h (oe %b) expected %h", t, ad_out, ad_oe, e);
    end
  end

  task automatic chk(string t, logic [7:0] act, logic [7:0] e);
    vecs++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic addr_phase(logic [15:0] a);
    @(posedge clk) #1;
    addr_hi = a[15:8]; ad_in = a[7:0]; ale = 1;
    @(posedge clk) #1;
    ale = 0; ad_in = 8'hA5;
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    addr_phase(a);
    @(posedge clk) #1; ad_in = d; wr = 1;
    @(posedge clk) #1; wr = 0; ad_in = 8'h3C;
    @(posedge clk) #1;
  endtask

  task automatic bus_rd(logic [15:0] a, logic [7:0] e, string t);
    addr_phase(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk) #1; rd = 1; smp = 1;
    @(posedge clk) #1; rd = 0; smp = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R4 pa_oe", pa_oe, 8'h00);
    chk("R4 pb_oe", pb_oe, 8'h00);
    chk("R4 pc_oe", pc_oe, 8'h00);
    chk("R4 pc_out", pc_out, 8'h00);
    bus_rd(16'h8003, 8'h9B, "R4 R11 ctrl reset");

    addr_phase(16'h1234); @(negedge clk);
    chk("R3 ram_cs low", {7'd0, ram_cs}, 8'd1); chk("R3 io_cs low", {7'd0, io_cs}, 8'd0);
    addr_phase(16'h7FFF); @(negedge clk);
    chk("R3 ram_cs 7FFF", {7'd0, ram_cs}, 8'd1);
    addr_phase(16'h8002); @(negedge clk);
    chk("R2 io_cs 8002", {7'd0, io_cs}, 8'd1); chk("R3 ram_cs 8002", {7'd0, ram_cs}, 8'd0);
    addr_phase(16'h8004); @(negedge clk);
    chk("R2 io_cs 8004", {7'd0, io_cs}, 8'd0);
    addr_phase(16'hFFFF); @(negedge clk);
    chk("R2 io_cs FFFF", {7'd0, io_cs}, 8'd0);

    addr_phase(16'h8001); @(negedge clk);
    chk("R1 held addr", {7'd0, io_cs}, 8'd1);

    addr_phase(16'h0010); rd = 1; @(negedge clk);
    chk("R10 ram read no drive", {7'd0, ad_oe}, 8'd0);
    #1 rd = 0;
    addr_phase(16'h8000); @(negedge clk);
    chk("R10 no rd no drive", {7'd0, ad_oe}, 8'd0);

    bus_wr(16'h8003, 8'h9A); @(negedge clk);
    chk("R5 9A pc_oe", pc_oe, 8'h0F);
    chk("R5 9A pa_oe", pa_oe, 8'h00);
    chk("R5 9A pb_oe", pb_oe, 8'h00);
    bus_rd(16'h8003, 8'h9A, "R11 ctrl 9A");

    bus_wr(16'h8002, 8'h5A); pc_in = 8'hC3;
    @(negedge clk); chk("R9 pc latch", pc_out, 8'h5A);
    bus_rd(16'h8002, 8'hCA, "R8 nibble mix");

    bus_wr(16'h8003, 8'h05); @(negedge clk);
    chk("R6 bsr set bit2", pc_out, 8'h5E);
    bus_wr(16'h8003, 8'h02); @(negedge clk);
    chk("R6 bsr clr bit1", pc_out, 8'h5C);
    chk("R6 dir kept", pc_oe, 8'h0F);

    bus_wr(16'h8003, 8'h80); @(negedge clk);
    chk("R7 clear pc", pc_out, 8'h00);
    chk("R5 80 pa_oe", pa_oe, 8'hFF);
    chk("R5 80 pc_oe", pc_oe, 8'hFF);
    bus_rd(16'h8003, 8'h80, "R11 ctrl 80");
    pa_in = 8'hEE;
    bus_wr(16'h8000, 8'h11);
    bus_wr(16'h8001, 8'h22);
    bus_rd(16'h8000, 8'h11, "R8 out port A");
    bus_rd(16'h8001, 8'h22, "R8 out port B");

    bus_wr(16'h8003, 8'h92); pa_in = 8'h3C; pb_in = 8'h71;
    @(negedge clk); chk("R7 clear pa", pa_out, 8'h00);
    bus_rd(16'h8000, 8'h3C, "R8 in port A");
    bus_rd(16'h8001, 8'h71, "R8 in port B");
    bus_rd(16'h8003, 8'h92, "R11 ctrl 92");

    bus_wr(16'h0003, 8'h9B);
    bus_wr(16'h0002, 8'hFF);
    @(negedge clk);
    chk("R9 ram write pc_oe", pc_oe, 8'hFF);
    chk("R9 ram write pc_out", pc_out, 8'h00);
    bus_rd(16'h8003, 8'h92, "R9 ctrl untouched");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule